// File: doc/BRIEF.md
# Bus-Master DMA Register Bank

This block holds the software-visible registers of a multi-channel bus-master disk DMA controller, two channels by default. Each channel has a command byte, a status byte that mixes read-only, write-one-to-clear and plain read/write bits, and a 32-bit descriptor-table pointer. A DMA engine beside the block reads the start, direction and pointer values. It reports completion, interrupt and error events back through per-channel pulse inputs.

The host reaches the registers through a 16-byte I/O window. The window is addressed by dword index (`addr_i`), and byte enables select the byte, word or dword lanes. Byte offset = 4 × `addr_i` + lane. Channel `c` occupies dword indices 2c (control dword) and 2c+1 (pointer dword). In the control dword, lane 0 is the command byte and lane 2 is the status byte. Lanes 1 and 3 are unimplemented. Writes take effect at the clock edge that samples the request. A read returns the whole addressed dword one cycle after the request.

Top module: `bmdma_regs`

## Requirements
- R1: After reset, or after reset is asserted mid-run, every command, status and pointer register of every channel reads zero, and `start_o`, `dir_o` and `prd_base_o` are zero.
- R2: Channel c uses dword index 2c for its control dword and 2c+1 for its pointer. A write to one channel leaves every register of the other channel unchanged.
- R3: In a control dword read, lanes 1 and 3 (bits 15:8 and 31:24) always return 0xFF. Writes to those lanes have no effect.
- R4: The command byte stores only bit 0 (start, driven on `start_o`) and bit 3 (direction, driven on `dir_o`). Its other bits read as zero.
- R5: A status write copies written bits 6 and 5 into status. Status bits 7, 4 and 3 always read zero.
- R6: Status bits 2 (interrupt) and 1 (error) clear when a status write has a 1 in that bit position. They hold when the written bit is 0.
- R7: Status bit 0 (active) takes command bit 0 on every command write. A status write never changes it. A `done_i` pulse clears it, except in a cycle that also writes the command, where the command write wins.
- R8: `irq_set_i` sets status bit 2 and `err_set_i` sets status bit 1 at the next edge. Each wins over a same-cycle write-one-to-clear of that bit.
- R9: Pointer bits 1:0 always read zero, on the bus and on `prd_base_o`, whatever value is written.
- R10: A pointer write updates only the byte lanes whose byte enable is set. Byte, word and dword writes are all supported.
- R11: `rvalid_o` is high exactly one cycle after each read request and low otherwise. `rdata_o` then holds the addressed dword as it stood before that request's edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 2 | Dword index in the window |
| be_i | input | 4 | Byte-lane enables for writes |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid with rvalid_o |
| rvalid_o | output | 1 | Read data valid, one cycle after a read |
| start_o | output | 2 | Per-channel start bit from the command byte |
| dir_o | output | 2 | Per-channel direction bit from the command byte |
| prd_base_o | output | 64 | Per-channel descriptor pointer, channel c at bits 32c+31:32c |
| done_i | input | 2 | Per-channel transfer-complete pulse, clears active |
| irq_set_i | input | 2 | Per-channel interrupt-flag set request |
| err_set_i | input | 2 | Per-channel error-flag set request |

## Verification
Register state and the engine-side outputs (`start_o`, `dir_o`, `prd_base_o`) change one edge after a write or a set/done pulse. The bench checks those outputs at the falling edge right after that edge. Read data is due one edge after the read request. The driver pushes the expected dword into a queue when it issues the read. The monitor pops from the queue only on falling edges where `rvalid_o` is high, so an early, late, missing or extra response shows up as a mismatch or as an item left over.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned LANES     = DATA_W / 8;
  localparam logic [7:0]  NOIMP_BYTE = 8'hFF;

  typedef struct packed {
    logic dir;
    logic start;
  } cmd_t;

  typedef struct packed {
    logic cap1;
    logic cap0;
    logic irq;
    logic err;
    logic act;
  } sts_t;

  function automatic logic [7:0] cmd_to_byte(cmd_t c);
    return {4'b0000, c.dir, 2'b00, c.start};
  endfunction

  function automatic logic [7:0] sts_to_byte(sts_t s);
    return {1'b0, s.cap1, s.cap0, 2'b00, s.irq, s.err, s.act};
  endfunction
endpackage

// File: rtl/bmdma_chan.sv
module bmdma_chan
  import bmdma_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic              prd_we_i,
  input  logic [LANES-1:0]  be_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              done_i,
  input  logic              irq_set_i,
  input  logic              err_set_i,
  output logic [DATA_W-1:0] ctrl_rd_o,
  output logic [DATA_W-1:0] prd_rd_o,
  output logic              start_o,
  output logic              dir_o
);
  cmd_t              cmd_q;
  sts_t              sts_q, sts_d;
  logic [DATA_W-1:0] prd_q;
  logic              cmd_wr, sts_wr;
  logic [7:0]        sd;

  assign cmd_wr = ctrl_we_i & be_i[0];
  assign sts_wr = ctrl_we_i & be_i[2];
  assign sd     = wdata_i[23:16];

  always_comb begin
    sts_d = sts_q;
    if (cmd_wr)      sts_d.act = wdata_i[0];
    else if (done_i) sts_d.act = 1'b0;
    sts_d.irq = irq_set_i | (sts_q.irq & ~(sts_wr & sd[2]));
    sts_d.err = err_set_i | (sts_q.err & ~(sts_wr & sd[1]));
    if (sts_wr) begin
      sts_d.cap1 = sd[6];
      sts_d.cap0 = sd[5];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= '0;
      sts_q <= '0;
    end else begin
      if (cmd_wr) begin
        cmd_q.start <= wdata_i[0];
        cmd_q.dir   <= wdata_i[3];
      end
      sts_q <= sts_d;
    end
  end

  // pointer: per-lane update, dword aligned
  for (genvar b = 0; b < LANES; b++) begin : g_prd_lane
    logic [7:0] lane_wd;
    if (b == 0) begin : g_low
      assign lane_wd = {wdata_i[7:2], 2'b00};
    end else begin : g_hi
      assign lane_wd = wdata_i[8*b +: 8];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 prd_q[8*b +: 8] <= '0;
      else if (prd_we_i && be_i[b]) prd_q[8*b +: 8] <= lane_wd;
    end
  end

  assign ctrl_rd_o = {NOIMP_BYTE, sts_to_byte(sts_q), NOIMP_BYTE, cmd_to_byte(cmd_q)};
  assign prd_rd_o  = prd_q;
  assign start_o   = cmd_q.start;
  assign dir_o     = cmd_q.dir;

  AST_ACT_FOLLOWS_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_wr |=> (sts_q.act == $past(wdata_i[0]))); // R7
  AST_DONE_CLEARS_ACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !cmd_wr) |=> !sts_q.act); // R7
  AST_STS_WR_KEEPS_ACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_wr && !cmd_wr && !done_i) |=> $stable(sts_q.act)); // R7
  AST_IRQ_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_set_i |=> sts_q.irq); // R8
  AST_ERR_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_set_i |=> sts_q.err); // R8
  AST_IRQ_W1C: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_wr && sd[2] && !irq_set_i) |=> !sts_q.irq); // R6
  AST_PRD_LANE1_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prd_we_i && !be_i[1]) |=> $stable(prd_q[15:8])); // R10
  AST_PRD_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prd_rd_o[1:0] == 2'b00); // R9
endmodule

// File: rtl/bmdma_rdmux.sv
module bmdma_rdmux
  import bmdma_pkg::*;
#(
  parameter int unsigned N_WORDS = 4,
  localparam int unsigned SEL_W  = $clog2(N_WORDS)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      rd_en_i,
  input  logic [SEL_W-1:0]          sel_i,
  input  logic [N_WORDS*DATA_W-1:0] words_i,
  output logic [DATA_W-1:0]         rdata_o,
  output logic                      rvalid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= rd_en_i;
      if (rd_en_i) rdata_o <= words_i[sel_i*DATA_W +: DATA_W];
    end
  end

  AST_RVALID_AFTER_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> rvalid_o); // R11
  AST_NO_SPURIOUS_RVALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> !rvalid_o); // R11
endmodule

// File: rtl/bmdma_regs.sv
module bmdma_regs
  import bmdma_pkg::*;
#(
  parameter int unsigned NUM_CH = 2,
  localparam int unsigned N_WORDS = NUM_CH * 2,
  localparam int unsigned ADDR_W  = $clog2(N_WORDS)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_i,
  input  logic                     we_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [LANES-1:0]         be_i,
  input  logic [DATA_W-1:0]        wdata_i,
  output logic [DATA_W-1:0]        rdata_o,
  output logic                     rvalid_o,
  output logic [NUM_CH-1:0]        start_o,
  output logic [NUM_CH-1:0]        dir_o,
  output logic [NUM_CH*DATA_W-1:0] prd_base_o,
  input  logic [NUM_CH-1:0]        done_i,
  input  logic [NUM_CH-1:0]        irq_set_i,
  input  logic [NUM_CH-1:0]        err_set_i
);
  logic                      wr_en;
  logic [N_WORDS*DATA_W-1:0] words;

  assign wr_en = req_i & we_i;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic ctrl_we, prd_we;
    logic [DATA_W-1:0] prd_w;
    assign ctrl_we = wr_en && (addr_i == ADDR_W'(2*c));
    assign prd_we  = wr_en && (addr_i == ADDR_W'(2*c+1));

    bmdma_chan u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .ctrl_we_i (ctrl_we),
      .prd_we_i  (prd_we),
      .be_i      (be_i),
      .wdata_i   (wdata_i),
      .done_i    (done_i[c]),
      .irq_set_i (irq_set_i[c]),
      .err_set_i (err_set_i[c]),
      .ctrl_rd_o (words[(2*c)*DATA_W +: DATA_W]),
      .prd_rd_o  (prd_w),
      .start_o   (start_o[c]),
      .dir_o     (dir_o[c])
    );
    assign words[(2*c+1)*DATA_W +: DATA_W] = prd_w;
    assign prd_base_o[c*DATA_W +: DATA_W]  = prd_w;
  end

  bmdma_rdmux #(.N_WORDS(N_WORDS)) u_rdmux (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_en_i  (req_i & ~we_i),
    .sel_i    (addr_i),
    .words_i  (words),
    .rdata_o  (rdata_o),
    .rvalid_o (rvalid_o)
  );
endmodule

// File: tb/bmdma_regs_tb_top.sv
module bmdma_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [1:0]  addr_i = '0;
  logic [3:0]  be_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        rvalid_o;
  logic [1:0]  start_o, dir_o;
  logic [63:0] prd_base_o;
  logic [1:0]  done_i = '0, irq_set_i = '0, err_set_i = '0;

  int n_run = 0, n_fail = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  bmdma_regs dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .be_i(be_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .rvalid_o(rvalid_o),
    .start_o(start_o), .dir_o(dir_o), .prd_base_o(prd_base_o),
    .done_i(done_i), .irq_set_i(irq_set_i), .err_set_i(err_set_i)
  );

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [3:0] be, logic [31:0] d);
    @(negedge clk);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; be_i = be; wdata_i = d;
    @(negedge clk);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  // driver: issue read and push expected item
  task automatic rd(logic [1:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    req_i = 1'b0;
  endtask

  // monitor: pop on every valid response
  always @(negedge clk) begin
    if (rvalid_o) begin
      if (exp_q.size() == 0) begin
        check("R11 unexpected rvalid", 64'(rvalid_o), 64'd0);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, 64'(rdata_o), 64'(e));
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1 reset state, R3 filler lanes
    check("R1 start/dir", {60'd0, start_o, dir_o}, 64'd0);
    check("R1 prd_base", prd_base_o, 64'd0);
    rd(2'd0, 32'hFF00FF00, "R1 R3 ch0 ctrl");
    rd(2'd1, 32'h0, "R1 ch0 prd");
    rd(2'd2, 32'hFF00FF00, "R1 R3 ch1 ctrl");
    rd(2'd3, 32'h0, "R1 ch1 prd");
    // R4 command bits, R7 active follows
    wr(2'd0, 4'b0001, 32'h0000_00FF);
    check("R4 start_o/dir_o", {62'd0, start_o[0], dir_o[0]}, 64'd3);
    rd(2'd0, 32'hFF01FF09, "R4 R7 cmd write");
    // R5 status 6,5 direct; 7,4,3 zero; act held
    wr(2'd0, 4'b0100, 32'h00FF_0000);
    rd(2'd0, 32'hFF61FF09, "R5 status write");
    // R3 filler lane write ignored
    wr(2'd0, 4'b1010, 32'h1234_5678);
    rd(2'd0, 32'hFF61FF09, "R3 filler write ignored");
    // R8 set requests
    @(negedge clk); irq_set_i[0] = 1'b1; err_set_i[0] = 1'b1;
    @(negedge clk); irq_set_i[0] = 1'b0; err_set_i[0] = 1'b0;
    rd(2'd0, 32'hFF67FF09, "R8 irq/err set");
    // R6 clear irq only, bit 0 written 0 keeps act (R7)
    wr(2'd0, 4'b0100, 32'h0004_0000);
    rd(2'd0, 32'hFF03FF09, "R6 R7 w1c irq");
    // R8 set wins over same-cycle clear
    @(negedge clk);
    req_i = 1'b1; we_i = 1'b1; addr_i = 2'd0; be_i = 4'b0100; wdata_i = 32'h0002_0000;
    err_set_i[0] = 1'b1;
    @(negedge clk);
    req_i = 1'b0; we_i = 1'b0; err_set_i[0] = 1'b0;
    rd(2'd0, 32'hFF03FF09, "R8 set beats clear");
    wr(2'd0, 4'b0100, 32'h0002_0000);
    rd(2'd0, 32'hFF01FF09, "R6 w1c err");
    // R7 done clears active
    @(negedge clk); done_i[0] = 1'b1;
    @(negedge clk); done_i[0] = 1'b0;
    rd(2'd0, 32'hFF00FF09, "R7 done clears act");
    // R2 other channel untouched
    rd(2'd2, 32'hFF00FF00, "R2 ch1 ctrl isolated");
    check("R2 ch1 start", {63'd0, start_o[1]}, 64'd0);
    // R9 alignment, R10 lane enables
    wr(2'd3, 4'b1111, 32'hDEAD_BEEF);
    check("R9 prd_base_o ch1", 64'(prd_base_o[63:32]), 64'hDEADBEEC);
    rd(2'd3, 32'hDEADBEEC, "R9 prd aligned");
    wr(2'd3, 4'b0010, 32'h0000_5500);
    rd(2'd3, 32'hDEAD55EC, "R10 byte write");
    wr(2'd3, 4'b1100, 32'h1234_0000);
    rd(2'd3, 32'h123455EC, "R10 word write");
    wr(2'd3, 4'b0001, 32'h0000_0013);
    rd(2'd3, 32'h12345510, "R9 R10 low byte");
    rd(2'd1, 32'h0, "R2 ch0 prd isolated");
    // R11 back-to-back reads, idle after
    @(negedge clk);
    req_i = 1'b1; we_i = 1'b0; addr_i = 2'd3;
    exp_q.push_back(32'h12345510); tag_q.push_back("R11 b2b first");
    @(negedge clk);
    addr_i = 2'd0;
    exp_q.push_back(32'hFF00FF09); tag_q.push_back("R11 b2b second");
    @(negedge clk);
    req_i = 1'b0;
    @(negedge clk);
    check("R11 rvalid idle", 64'(rvalid_o), 64'd0);
    check("R11 queue drained", 64'(exp_q.size()), 64'd0);
    // R1 reset mid-run
    @(negedge clk); rst_ni = 1'b0;
    @(negedge clk); rst_ni = 1'b1;
    check("R1 mid-run outputs", {prd_base_o[61:0], start_o}, 64'd0);
    rd(2'd0, 32'hFF00FF00, "R1 mid-run ctrl");
    rd(2'd3, 32'h0, "R1 mid-run prd");
    repeat (2) @(negedge clk);
    check("R11 final queue", 64'(exp_q.size()), 64'd0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule